// File: doc/BRIEF.md
# ADC Output Test Pattern Generator

This block sits on a converter's output data path and, when told to, replaces the live samples with known 16-bit words. Link bring-up and board test use it to check capture logic against values they can predict. Software programs it through a byte-wide write port. That port loads one control byte and eight user words.

The control byte selects a test mode: live pass-through, fixed levels, alternating checker or all-ones words, a ramp, or playback of user words. A sample enable sets the output rate. Each enabled cycle registers one output word and advances whichever sequence is running.

An SDR/DDR select changes which modes are legal. In DDR, user playback steps through the odd-numbered user words only. A calibration-busy input overrides everything with a fixed marker word. All words are MSB-justified raw codes for a 12-bit converter.

Top module: `adc_test_pattern`

## Requirements
- R1: After reset, the control byte and all user words are zero, the mode is live pass-through, and `pat_out` is 0x0000.
- R2: A write to address 0xC0 loads the control byte. The control byte holds the mode in bits 7:4 and the depth in bits 2:0; bit 3 is ignored. User word k (1 to 8) takes its low byte from address 0xC1+2(k-1) and its high byte from the address after that. Writes to any other address change nothing.
- R3: `pat_out` takes a new value only on the clock edge after a cycle with `smp_en` high, and holds otherwise.
- R4: Mode 0 passes `live_data` through. Reserved modes 5, 6, 9 and 11 to 15 do the same.
- R5: Mode 1 gives 0x8000, mode 2 gives 0xFFF0 and mode 3 gives 0x0000.
- R6: In SDR, mode 4 alternates 0xAAAA, 0x5555 and mode 7 alternates 0xFFFF, 0x0000, each starting with the first word. In DDR, modes 4 and 7 pass live data.
- R7: In SDR, mode 8 with depth N plays user words 1 through N+1 in order, then repeats.
- R8: In DDR, mode 8 with depth 0 to 3 plays words 1, 3, 5 and 7, stopping at word 2N+1, then repeats. Depth 4 to 7 passes live data.
- R9: Mode 10 outputs a ramp that starts at 0x0000 and adds 0x0010 per sample. After 0xFFF0 it wraps to 0x0000.
- R10: Every control-byte write restarts the user-word index at word 1, the alternating phase at its first word, and the ramp at 0x0000.
- R11: While `cal_busy` is high, each sample outputs 0xCCCC and no sequence advances. After `cal_busy` falls, each sequence continues from where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| ddr_sel | input | 1 | 1 selects DDR rules, 0 selects SDR rules |
| cal_busy | input | 1 | Calibration in progress |
| smp_en | input | 1 | Sample-rate enable |
| live_data | input | 16 | Live converter word, MSB-justified |
| pat_out | output | 16 | Registered output word |

## Verification
Two situations are hard to reach from the ports. The first is a calibration burst that lands in the middle of a user-word or ramp sequence. The second is a control write in the same cycle as a sample. Either one must leave the sequence state exactly right. Randomized stimulus raises `cal_busy` in bursts and issues control writes at random points. A bench model keeps its own index, phase and ramp and compares against every cycle. Directed runs cover the ramp wrap after 4096 samples and a restart in the middle of a sequence.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
    typedef enum logic [3:0] {
        MODE_LIVE  = 4'd0,
        MODE_MID   = 4'd1,
        MODE_PFS   = 4'd2,
        MODE_NFS   = 4'd3,
        MODE_CHECK = 4'd4,
        MODE_ONES  = 4'd7,
        MODE_USER  = 4'd8,
        MODE_RAMP  = 4'd10
    } tmode_e;

    // DDR playback supports only the odd-numbered words, so the depth is limited
    function automatic logic ddr_depth_ok(input logic [2:0] depth, input int npat);
        return int'(depth) <= (npat / 2 - 1);
    endfunction
endpackage

// File: rtl/tpg_regs.sv
module tpg_regs #(
    parameter int W         = 16,
    parameter int NPAT      = 8,
    parameter int ADDR_W    = 8,
    parameter int CTRL_ADDR = 'hC0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [7:0]                wr_data,
    output logic [7:0]                ctrl,
    output logic [NPAT-1:0][W-1:0]    pats,
    output logic                      ctrl_wr
);
    localparam int NBYTE = W / 8;

    typedef struct packed {
        logic [7:0]             ctrl;
        logic [NPAT-1:0][W-1:0] pat;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        ctrl_wr = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));
        if (ctrl_wr) begin
            r_d.ctrl = wr_data;
        end
        for (int k = 0; k < NPAT; k++) begin
            for (int b = 0; b < NBYTE; b++) begin
                if (wr_en && (wr_addr == ADDR_W'(CTRL_ADDR + 1 + k * NBYTE + b))) begin
                    r_d.pat[k][b*8 +: 8] = wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ctrl = r_q.ctrl;
    assign pats = r_q.pat;
endmodule

// File: rtl/tpg_seq.sv
module tpg_seq #(
    parameter int W     = 16,
    parameter int RES   = 12,
    parameter int NPAT  = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             smp_en,
    input  logic             hold,
    input  logic             ddr_sel,
    input  logic [3:0]       mode,
    input  logic [2:0]       depth,
    output logic [IDX_W-1:0] idx,
    output logic             phase,
    output logic [W-1:0]     ramp
);
    import tpg_pkg::*;

    localparam logic [W-1:0] STEP = W'(1) << (W - RES);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             phase;
        logic [W-1:0]     ramp;
    } seq_t;

    seq_t s_d, s_q;
    logic [IDX_W:0] dep_w;
    logic [IDX_W:0] ddr_last;

    always_comb begin
        s_d      = s_q;
        dep_w    = (IDX_W + 1)'(depth);
        ddr_last = dep_w << 1;
        if (restart) begin
            s_d = '0;
        end else if (smp_en && !hold) begin
            case (mode)
                MODE_CHECK, MODE_ONES: begin
                    if (!ddr_sel) begin
                        s_d.phase = ~s_q.phase;
                    end
                end
                MODE_USER: begin
                    if (!ddr_sel) begin
                        s_d.idx = ({1'b0, s_q.idx} >= dep_w) ? '0 : s_q.idx + IDX_W'(1);
                    end else if (ddr_depth_ok(depth, NPAT)) begin
                        s_d.idx = ({1'b0, s_q.idx} >= ddr_last) ? '0 : s_q.idx + IDX_W'(2);
                    end
                end
                MODE_RAMP: begin
                    s_d.ramp = s_q.ramp + STEP;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign idx   = s_q.idx;
    assign phase = s_q.phase;
    assign ramp  = s_q.ramp;
endmodule

// File: rtl/tpg_mux.sv
module tpg_mux #(
    parameter int W     = 16,
    parameter int RES   = 12,
    parameter int NPAT  = 8,
    parameter int IDX_W = 3
) (
    input  logic [3:0]             mode,
    input  logic [2:0]             depth,
    input  logic                   ddr_sel,
    input  logic                   cal_busy,
    input  logic [IDX_W-1:0]       idx,
    input  logic                   phase,
    input  logic [W-1:0]           ramp,
    input  logic [NPAT-1:0][W-1:0] pats,
    input  logic [W-1:0]           live,
    output logic [W-1:0]           word
);
    import tpg_pkg::*;

    localparam logic [W-1:0] LSB_MASK = (W'(1) << (W - RES)) - W'(1);
    localparam logic [W-1:0] MID_WORD = W'(1) << (W - 1);
    localparam logic [W-1:0] PFS_WORD = ~LSB_MASK;
    localparam logic [W-1:0] CAL_WORD = {(W/4){4'b1100}};
    localparam logic [W-1:0] ALT_A    = {(W/2){2'b10}};

    logic [IDX_W-1:0] ddr_idx;

    always_comb begin
        ddr_idx = {idx[IDX_W-1:1], 1'b0};
        word    = live;
        if (cal_busy) begin
            word = CAL_WORD;
        end else begin
            case (mode)
                MODE_MID: word = MID_WORD;
                MODE_PFS: word = PFS_WORD;
                MODE_NFS: word = '0;
                MODE_CHECK: begin
                    if (!ddr_sel) word = phase ? ~ALT_A : ALT_A;
                end
                MODE_ONES: begin
                    if (!ddr_sel) word = phase ? '0 : '1;
                end
                MODE_USER: begin
                    if (!ddr_sel) begin
                        word = pats[idx];
                    end else if (ddr_depth_ok(depth, NPAT)) begin
                        word = pats[ddr_idx];
                    end
                end
                MODE_RAMP: word = ramp;
                default: word = live;
            endcase
        end
    end
endmodule

// File: rtl/adc_test_pattern.sv
module adc_test_pattern #(
    parameter int W         = 16,
    parameter int RES       = 12,
    parameter int NPAT      = 8,
    parameter int ADDR_W    = 8,
    parameter int CTRL_ADDR = 'hC0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              ddr_sel,
    input  logic              cal_busy,
    input  logic              smp_en,
    input  logic [W-1:0]      live_data,
    output logic [W-1:0]      pat_out
);
    localparam int IDX_W = $clog2(NPAT);

    logic [7:0]             ctrl_byte;
    logic [NPAT-1:0][W-1:0] pat_bank;
    logic                   ctrl_wr;
    logic [IDX_W-1:0]       seq_idx;
    logic                   seq_phase;
    logic [W-1:0]           ramp_val;
    logic [W-1:0]           mux_word;

    typedef struct packed {
        logic [W-1:0] word;
    } out_t;

    out_t o_d, o_q;

    tpg_regs #(.W(W), .NPAT(NPAT), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ctrl    (ctrl_byte),
        .pats    (pat_bank),
        .ctrl_wr (ctrl_wr)
    );

    tpg_seq #(.W(W), .RES(RES), .NPAT(NPAT), .IDX_W(IDX_W)) i_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (ctrl_wr),
        .smp_en  (smp_en),
        .hold    (cal_busy),
        .ddr_sel (ddr_sel),
        .mode    (ctrl_byte[7:4]),
        .depth   (ctrl_byte[2:0]),
        .idx     (seq_idx),
        .phase   (seq_phase),
        .ramp    (ramp_val)
    );

    tpg_mux #(.W(W), .RES(RES), .NPAT(NPAT), .IDX_W(IDX_W)) i_mux (
        .mode     (ctrl_byte[7:4]),
        .depth    (ctrl_byte[2:0]),
        .ddr_sel  (ddr_sel),
        .cal_busy (cal_busy),
        .idx      (seq_idx),
        .phase    (seq_phase),
        .ramp     (ramp_val),
        .pats     (pat_bank),
        .live     (live_data),
        .word     (mux_word)
    );

    always_comb begin
        o_d = o_q;
        if (smp_en) begin
            o_d.word = mux_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign pat_out = o_q.word;
endmodule

// File: rtl/tpg_checker.sv
module tpg_checker #(
    parameter int W         = 16,
    parameter int ADDR_W    = 8,
    parameter int CTRL_ADDR = 'hC0,
    parameter int IDX_W     = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              ddr_sel,
    input logic              cal_busy,
    input logic              smp_en,
    input logic [3:0]        mode,
    input logic [IDX_W-1:0]  seq_idx,
    input logic [W-1:0]      pat_out
);
    localparam logic [W-1:0] CAL_WORD = {(W/4){4'b1100}};
    localparam logic [W-1:0] ALT_A    = {(W/2){2'b10}};

    AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_en |=> $stable(pat_out)); // R3

    AST_CAL_MARKER: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_en && cal_busy) |=> (pat_out == CAL_WORD)); // R11

    AST_CTRL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(CTRL_ADDR)) |=> (seq_idx == '0)); // R10

    AST_RAMP_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_en && !cal_busy && mode == 4'd10) |=> (pat_out[3:0] == 4'h0)); // R9

    AST_CHECK_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_en && !cal_busy && !ddr_sel && mode == 4'd4)
        |=> (pat_out == ALT_A || pat_out == ~ALT_A)); // R6
endmodule

bind adc_test_pattern tpg_checker #(
    .W(W), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .IDX_W(IDX_W)
) i_tpg_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .ddr_sel  (ddr_sel),
    .cal_busy (cal_busy),
    .smp_en   (smp_en),
    .mode     (ctrl_byte[7:4]),
    .seq_idx  (seq_idx),
    .pat_out  (pat_out)
);

// File: tb/test_adc_test_pattern.sv
module test_adc_test_pattern;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        ddr_sel = 1'b0;
    logic        cal_busy = 1'b0;
    logic        smp_en = 1'b0;
    logic [15:0] live_data = '0;
    logic [15:0] pat_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #10 clk = ~clk;

    adc_test_pattern i_adc_test_pattern (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ddr_sel(ddr_sel), .cal_busy(cal_busy), .smp_en(smp_en),
        .live_data(live_data), .pat_out(pat_out)
    );

    // bench model state
    logic [7:0]  m_ctrl = '0;
    logic [15:0] m_pat [8];
    logic [2:0]  m_idx = '0;
    logic        m_ph = 1'b0;
    logic [15:0] m_ramp = '0;
    logic [15:0] m_out = '0;
    string       m_tag = "R1";

    function automatic logic [15:0] exp_word(input logic [15:0] live);
        logic [3:0] md  = m_ctrl[7:4];
        logic [2:0] dep = m_ctrl[2:0];
        if (cal_busy) return 16'hCCCC;
        case (md)
            4'd1: return 16'h8000;
            4'd2: return 16'hFFF0;
            4'd3: return 16'h0000;
            4'd4: return ddr_sel ? live : (m_ph ? 16'h5555 : 16'hAAAA);
            4'd7: return ddr_sel ? live : (m_ph ? 16'h0000 : 16'hFFFF);
            4'd8: begin
                if (!ddr_sel) return m_pat[m_idx];
                if (dep > 3) return live;
                return m_pat[{m_idx[2:1], 1'b0}];
            end
            4'd10: return m_ramp;
            default: return live;
        endcase
    endfunction

    function automatic string tag_now();
        logic [3:0] md = m_ctrl[7:4];
        if (!smp_en) return "R3";
        if (cal_busy) return "R11";
        case (md)
            4'd1, 4'd2, 4'd3: return "R5";
            4'd4, 4'd7: return "R6";
            4'd8: return ddr_sel ? "R8" : "R7";
            4'd10: return "R9";
            default: return "R4";
        endcase
    endfunction

    task automatic model_step();
        logic [3:0] md = m_ctrl[7:4];
        logic [2:0] dep = m_ctrl[2:0];
        int off;
        m_tag = tag_now();
        if (smp_en) m_out = exp_word(live_data);
        if (smp_en && !cal_busy) begin
            if ((md == 4 || md == 7) && !ddr_sel) m_ph = ~m_ph;
            if (md == 10) m_ramp = m_ramp + 16'h0010;
            if (md == 8) begin
                if (!ddr_sel) m_idx = (m_idx >= dep) ? 3'd0 : m_idx + 3'd1;
                else if (dep <= 3) m_idx = ({1'b0, m_idx} >= {dep, 1'b0}) ? 3'd0 : m_idx + 3'd2;
            end
        end
        if (wr_en) begin
            if (wr_addr == 8'hC0) begin
                m_ctrl = wr_data; m_idx = '0; m_ph = 1'b0; m_ramp = '0;
            end else if (wr_addr >= 8'hC1 && wr_addr <= 8'hD0) begin
                off = int'(wr_addr) - 'hC1;
                if (off % 2 == 0) m_pat[off/2][7:0] = wr_data;
                else m_pat[off/2][15:8] = wr_data;
            end
        end
    endtask

    task automatic chk(input logic [15:0] got, input logic [15:0] exp, input string tag);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: pat_out=%h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        #1;
        chk(pat_out, m_out, m_tag);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d; smp_en = 1'b0;
        cyc();
    endtask

    task automatic samples(input int n);
        for (int i = 0; i < n; i++) begin
            smp_en = 1'b1; live_data = 16'($urandom);
            cyc();
        end
        smp_en = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 8; i++) m_pat[i] = '0;
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(negedge clk);
        #1 chk(pat_out, 16'h0000, "R1");
        rst_n = 1'b1;
        @(negedge clk);

        // R4 live pass-through, R1 default mode
        smp_en = 1'b1; live_data = 16'h1234; cyc();
        chk(pat_out, 16'h1234, "R4");
        smp_en = 1'b0;

        // R2 load user words, then stray writes around the window
        for (int k = 0; k < 8; k++) begin
            wr(8'(8'hC1 + 2*k), 8'(8'h10 + k));
            wr(8'(8'hC2 + 2*k), 8'(8'hA0 + k));
        end
        wr(8'hBF, 8'h5A); wr(8'hD1, 8'h5A);
        wr(8'hC0, 8'h87);
        smp_en = 1'b1; cyc(); chk(pat_out, 16'hA010, "R2");
        cyc(); chk(pat_out, 16'hA111, "R7");
        samples(14);
        for (int k = 7; k < 8; k++) begin
            smp_en = 1'b1; cyc(); // index wraps back to word 1 here
        end
        smp_en = 1'b0;
        // R3 hold with no sample
        repeat (4) cyc();

        // R7 shorter depth, bit 3 ignored per R2
        wr(8'hC0, 8'h8A); samples(9);
        // R8 DDR depths
        ddr_sel = 1'b1;
        wr(8'hC0, 8'h83);
        smp_en = 1'b1; cyc(); chk(pat_out, 16'hA010, "R8");
        cyc(); chk(pat_out, 16'hA212, "R8");
        samples(8);
        wr(8'hC0, 8'h81); samples(5);
        wr(8'hC0, 8'h85); samples(4);
        // R6 in DDR passes live
        wr(8'hC0, 8'h40); samples(3);
        wr(8'hC0, 8'h70); samples(3);
        ddr_sel = 1'b0;
        wr(8'hC0, 8'h40);
        smp_en = 1'b1; cyc(); chk(pat_out, 16'hAAAA, "R6");
        cyc(); chk(pat_out, 16'h5555, "R6");
        smp_en = 1'b0;
        wr(8'hC0, 8'h70); samples(5);
        // R5 fixed levels
        wr(8'hC0, 8'h10); samples(2);
        wr(8'hC0, 8'h20); samples(2);
        wr(8'hC0, 8'h30); samples(2);
        // R4 reserved codes
        wr(8'hC0, 8'h50); samples(2);
        wr(8'hC0, 8'hF0); samples(2);

        // R9 ramp through full wrap
        wr(8'hC0, 8'hA0);
        smp_en = 1'b1; cyc(); chk(pat_out, 16'h0000, "R9");
        samples(4095);
        smp_en = 1'b1; cyc(); chk(pat_out, 16'h0000, "R9");
        smp_en = 1'b0;

        // R10 restart mid-sequence
        wr(8'hC0, 8'h87); samples(3);
        wr(8'hC0, 8'h87);
        smp_en = 1'b1; cyc(); chk(pat_out, 16'hA010, "R10");
        smp_en = 1'b0;

        // R11 calibration burst mid-sequence, then resume
        samples(2);
        cal_busy = 1'b1; samples(5);
        cal_busy = 1'b0;
        smp_en = 1'b1; cyc(); chk(pat_out, 16'hA313, "R11");
        smp_en = 1'b0;

        // randomized phase
        for (int i = 0; i < 6000; i++) begin
            int r = int'($urandom_range(0, 99));
            if (r < 6) begin
                logic [3:0] md;
                int pick = int'($urandom_range(0, 9));
                case (pick)
                    0: md = 4'd8; 1: md = 4'd8; 2: md = 4'd10; 3: md = 4'd4; 4: md = 4'd7;
                    5: md = 4'd1; 6: md = 4'd2; 7: md = 4'd3; 8: md = 4'd0;
                    default: md = 4'($urandom);
                endcase
                ddr_sel = 1'($urandom);
                wr_en = 1'b1; wr_addr = 8'hC0; wr_data = {md, 4'($urandom)};
            end else if (r < 12) begin
                wr_en = 1'b1; wr_addr = 8'($urandom_range(8'hBE, 8'hD3)); wr_data = 8'($urandom);
            end
            if ($urandom_range(0, 99) < 4) cal_busy = ~cal_busy;
            smp_en = ($urandom_range(0, 99) < 70);
            live_data = 16'($urandom);
            cyc();
        end
        cal_busy = 1'b0; smp_en = 1'b0;

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule